// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block takes in an asynchronous serial line and turns each character into a byte in a receive data register. Timing comes from an external tick that runs at sixteen times the bit rate. Each bit is decided by a majority vote over samples 7, 8 and 9 of its sixteen. A frame has one low start bit, eight data bits sent least significant bit first, an optional even or odd parity bit, and one stop bit.

Five flags report what happened: receive-data-full, framing error, parity error, overrun, and error-signal status. The error-signal flag is for smart-card style reporting, where the far end pulls the line low in the slot after the parity bit. Every flag is sticky. A flag clears only when a status read has seen it at 1 and a later write puts 0 in its bit position. While any error flag is set, the receiver accepts no new frames. The interrupt line is high whenever any flag is set.

A bus master reads status at address 0 and data at address 1, using one-cycle read and write strobes. An enable input gates reception.

Top module: `uart_rx_sticky`

## Requirements
- R1: After reset, all five flags, the data register and the interrupt output are 0.
- R2: A frame is one start bit, eight data bits with the least significant bit first, and one stop bit. Parity mode is set by `par_mode`: 00 gives no parity bit, 01 gives even parity, 10 gives odd parity, and 11 behaves as 00. A frame with a high stop bit and correct parity, received while the full flag is clear, stores its byte and sets the full flag.
- R3: A start bit is accepted only if the majority of samples 7, 8 and 9 after the falling edge are low. A shorter low pulse produces no frame and changes no flag.
- R4: If a frame completes while the full flag is 1, the overrun flag sets, the data register keeps its old byte and the new byte is discarded.
- R5: With parity enabled, a frame whose parity bit is wrong sets the parity flag and writes its byte to the data register, but does not set the full flag.
- R6: With parity disabled, a low stop bit sets the framing flag. The byte is discarded and the full flag does not set.
- R7: With parity enabled, a low line at the sample point one bit after the parity bit sets the error-signal flag. The byte is still handled by R2 and R5.
- R8: While any of the framing, parity, overrun or error-signal flags is 1, incoming frames are ignored: the data register and the full flag do not change.
- R9: Status is at address 0, with the full flag in bit 0, framing in bit 1, parity in bit 2, overrun in bit 3 and error-signal in bit 4. Data is at address 1. A status write of 0 to a bit clears that flag only if the most recent status read since the last status write saw it at 1. Writing 1 to a bit, or writing to the data address, changes nothing.
- R10: While `rx_en` is low, no frame is received, and all flags keep their values.
- R11: `irq` is 1 exactly when at least one flag is 1.
- R12: If a valid clear of the full flag falls in the same cycle that a frame completes, the clear takes effect first. The new byte is stored, the full flag stays 1, and no overrun is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_in | input | 1 | Serial line; idles high |
| rx_en | input | 1 | Receive enable |
| par_mode | input | 2 | 00/11 no parity, 01 even, 10 odd |
| bus_addr | input | 1 | 0 selects status, 1 selects data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| rx_data | output | 8 | Receive data register |
| full | output | 1 | Receive-data-full flag |
| frm_err | output | 1 | Framing error flag |
| par_err | output | 1 | Parity error flag |
| ovr_err | output | 1 | Overrun flag |
| esig_err | output | 1 | Error-signal status flag |
| irq | output | 1 | Interrupt request |

## Verification
The case that needs care is a software clear of the full flag landing in the same clock as the completion of the next frame. The bench provokes it in two steps. First it receives a frame with the full flag clear and measures, from a fixed baud-tick phase, how many cycles pass before the flag rises. It then replays the same frame at the same phase while the full flag is already set. A read of the status register comes first, and the clearing write is timed so that its strobe covers exactly that completion edge. The result counts as correct only if the new byte is in the data register, the full flag is 1 and the overrun flag is 0.

// File: rtl/uart_rx_sticky.sv
module uart_rx_sticky #(
  parameter int DW = 8,
  parameter int OS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          baud_tick,
  input  logic          rx_in,
  input  logic          rx_en,
  input  logic [1:0]    par_mode,
  input  logic          bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic [DW-1:0] rx_data,
  output logic          full,
  output logic          frm_err,
  output logic          par_err,
  output logic          ovr_err,
  output logic          esig_err,
  output logic          irq
);
  localparam int CW = $clog2(OS);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] MID = CW'(OS/2 + 1);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);

  typedef enum logic [2:0] {S_HUNT, S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t st;
  logic rx_q1, rx_q2;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic s_a, s_b, par_bit;
  logic [DW-1:0] shreg;
  logic [4:0] seen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_q1 <= 1'b1;
      rx_q2 <= 1'b1;
    end else begin
      rx_q1 <= rx_in;
      rx_q2 <= rx_q1;
    end

  wire par_on = (par_mode == 2'b01) || (par_mode == 2'b10);
  wire vote = (s_a & s_b) | (s_a & rx_q2) | (s_b & rx_q2);
  wire mid = baud_tick && (cnt == MID);
  wire last = baud_tick && (cnt == LAST);
  wire err_any = frm_err | par_err | ovr_err | esig_err;
  wire [4:0] status = {esig_err, ovr_err, par_err, frm_err, full};

  wire st_wr = bus_wr && !bus_addr;
  wire [4:0] clr = {5{st_wr}} & ~bus_wdata[4:0] & seen;

  wire done = (st == S_STOP) && mid;
  wire par_bad = par_on && (par_bit != ((^shreg) ^ (par_mode == 2'b10)));
  wire full_eff = full & ~clr[0];
  wire ev_ovr = done & full_eff;
  wire ev_frm = done & ~full_eff & ~par_on & ~vote;
  wire ev_par = done & ~full_eff & par_bad;
  wire ev_good = done & ~full_eff & ~par_bad & (par_on | vote);
  wire ev_esig = done & par_on & ~vote;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_HUNT;
      cnt <= '0;
      bitn <= '0;
      s_a <= 1'b1;
      s_b <= 1'b1;
      par_bit <= 1'b0;
      shreg <= '0;
    end else if (!rx_en) begin
      st <= S_HUNT;
      cnt <= '0;
    end else begin
      if (baud_tick && cnt == MID - 2) s_a <= rx_q2;
      if (baud_tick && cnt == MID - 1) s_b <= rx_q2;
      if (baud_tick && st != S_IDLE && st != S_HUNT) cnt <= cnt + 1'b1;
      case (st)
        S_HUNT: if (rx_q2) st <= S_IDLE;
        S_IDLE: if (baud_tick && !rx_q2 && !err_any) begin
          st <= S_START;
          cnt <= CW'(1);
        end
        S_START: begin
          if (mid && vote) st <= S_HUNT;
          else if (last) begin
            st <= S_DATA;
            bitn <= '0;
          end
        end
        S_DATA: begin
          if (mid) shreg <= {vote, shreg[DW-1:1]};
          if (last) begin
            if (bitn == BW'(DW - 1)) st <= par_on ? S_PAR : S_STOP;
            else bitn <= bitn + 1'b1;
          end
        end
        S_PAR: begin
          if (mid) par_bit <= vote;
          if (last) st <= S_STOP;
        end
        S_STOP: if (mid) st <= S_HUNT;
        default: st <= S_HUNT;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_data <= '0;
      full <= 1'b0;
      frm_err <= 1'b0;
      par_err <= 1'b0;
      ovr_err <= 1'b0;
      esig_err <= 1'b0;
      seen <= '0;
    end else begin
      if (ev_good | ev_par) rx_data <= shreg;
      full <= ev_good ? 1'b1 : (clr[0] ? 1'b0 : full);
      frm_err <= ev_frm ? 1'b1 : (clr[1] ? 1'b0 : frm_err);
      par_err <= ev_par ? 1'b1 : (clr[2] ? 1'b0 : par_err);
      ovr_err <= ev_ovr ? 1'b1 : (clr[3] ? 1'b0 : ovr_err);
      esig_err <= ev_esig ? 1'b1 : (clr[4] ? 1'b0 : esig_err);
      if (st_wr) seen <= '0;
      else if (bus_rd && !bus_addr) seen <= status;
    end

  assign bus_rdata = bus_addr ? 8'(rx_data) : {3'b000, status};
  assign irq = |status;

  // R9
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full) |-> $past(bus_wr && !bus_addr && !bus_wdata[0]));
  // R9
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_err) |-> $past(bus_wr && !bus_addr && !bus_wdata[3]));
  // R4
  ovr_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err) |-> $stable(rx_data));
  // R5
  par_no_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(par_err) |-> !$rose(full));
  // R8
  blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_any && st == S_IDLE) |=> st != S_START);
  // R10
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == S_HUNT));
  // R11
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($countones(status) > 0));
endmodule

// File: tb/uart_rx_sticky_bench.sv
module uart_rx_sticky_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rx = 1'b1, en = 1'b1;
  logic [1:0] pm = 2'b00;
  logic addr = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata, data;
  logic full, frm, per, ovr, esig, irq;
  int vec = 0, bad = 0, dcal = 0;
  logic [7:0] tmp;

  uart_rx_sticky u_uart_rx_sticky (
    .clk(clk), .rst_n(rst_n), .baud_tick(tick), .rx_in(rx), .rx_en(en),
    .par_mode(pm), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .rx_data(data), .full(full), .frm_err(frm), .par_err(per),
    .ovr_err(ovr), .esig_err(esig), .irq(irq));

  always #5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic bus_write(input logic a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic clear_all();
    logic [7:0] s;
    bus_read(1'b0, s);
    bus_write(1'b0, 8'h00);
  endtask

  task automatic align();
    @(negedge clk);
    while (tick !== 1'b0) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    rx = b;
    repeat (32) @(negedge clk);
  endtask

  task automatic frame_body(input logic [7:0] b, input logic [1:0] m, input logic flip, input logic stopv);
    put_bit(1'b0);
    for (int i = 0; i < 8; i++) put_bit(b[i]);
    if (m == 2'b01) put_bit((^b) ^ flip);
    if (m == 2'b10) put_bit(~(^b) ^ flip);
    put_bit(stopv);
    rx = 1'b1;
    repeat (48) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic [1:0] m, input logic flip, input logic stopv);
    pm = m;
    align();
    frame_body(b, m, flip, stopv);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", {3'b0, esig, ovr, per, frm, full}, 8'h00);
    chk("R1 data", data, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 sweep all bytes across parity modes
    for (int b = 0; b < 256; b++) begin
      logic [1:0] m;
      m = (b % 3 == 0) ? 2'b00 : ((b % 3 == 1) ? 2'b01 : 2'b10);
      if (b == 255) m = 2'b11;
      send(8'(b), m, 1'b0, 1'b1);
      chk("R2 data", data, 8'(b));
      bus_read(1'b0, tmp);
      chk("R2 status", tmp, 8'h01);
      chk("R11 irq set", {7'b0, irq}, 8'h01);
      bus_write(1'b0, 8'h00);
      chk("R9 cleared", {3'b0, esig, ovr, per, frm, full}, 8'h00);
      chk("R11 irq clear", {7'b0, irq}, 8'h00);
    end

    // R3 short low glitch rejected
    align(); rx = 1'b0; repeat (4) @(negedge clk); rx = 1'b1;
    repeat (600) @(negedge clk);
    chk("R3 glitch", {3'b0, esig, ovr, per, frm, full}, 8'h00);

    // R4 overrun
    send(8'hA5, 2'b00, 1'b0, 1'b1);
    send(8'h3C, 2'b00, 1'b0, 1'b1);
    chk("R4 status", {3'b0, esig, ovr, per, frm, full}, 8'h09);
    chk("R4 data kept", data, 8'hA5);
    // R9 write without read, write of ones, data-address write
    bus_write(1'b0, 8'h00);
    chk("R9 no read", {3'b0, esig, ovr, per, frm, full}, 8'h09);
    bus_read(1'b0, tmp);
    bus_write(1'b0, 8'hFF);
    chk("R9 ones", {3'b0, esig, ovr, per, frm, full}, 8'h09);
    bus_read(1'b0, tmp);
    bus_write(1'b1, 8'h00);
    chk("R9 data addr", {3'b0, esig, ovr, per, frm, full}, 8'h09);
    bus_read(1'b1, tmp);
    chk("R9 data read", tmp, 8'hA5);
    clear_all();
    chk("R9 clear", {3'b0, esig, ovr, per, frm, full}, 8'h00);

    // R5 parity error, then R8 blocking
    send(8'h5A, 2'b01, 1'b1, 1'b1);
    chk("R5 status", {3'b0, esig, ovr, per, frm, full}, 8'h04);
    chk("R5 data", data, 8'h5A);
    chk("R11 irq err", {7'b0, irq}, 8'h01);
    send(8'h77, 2'b01, 1'b0, 1'b1);
    chk("R8 status", {3'b0, esig, ovr, per, frm, full}, 8'h04);
    chk("R8 data", data, 8'h5A);
    clear_all();
    send(8'h81, 2'b10, 1'b1, 1'b1);
    chk("R5 odd", {3'b0, esig, ovr, per, frm, full}, 8'h04);
    clear_all();

    // R6 framing
    send(8'hC3, 2'b00, 1'b0, 1'b0);
    chk("R6 status", {3'b0, esig, ovr, per, frm, full}, 8'h02);
    chk("R6 data", data, 8'h81);
    // R10 disable keeps flags
    en = 1'b0;
    repeat (10) @(negedge clk);
    chk("R10 flags kept", {3'b0, esig, ovr, per, frm, full}, 8'h02);
    clear_all();
    send(8'h11, 2'b00, 1'b0, 1'b1);
    chk("R10 no rx", {3'b0, esig, ovr, per, frm, full}, 8'h00);
    en = 1'b1;
    repeat (4) @(negedge clk);

    // R7 error signal
    send(8'h6E, 2'b01, 1'b0, 1'b0);
    chk("R7 status", {3'b0, esig, ovr, per, frm, full}, 8'h11);
    chk("R7 data", data, 8'h6E);
    send(8'h12, 2'b01, 1'b0, 1'b1);
    chk("R8 esig blocks", data, 8'h6E);
    clear_all();

    // R12 calibrate completion cycle
    pm = 2'b00;
    align();
    fork
      frame_body(8'h42, 2'b00, 1'b0, 1'b1);
      begin
        int c = 0;
        while (full !== 1'b1 && c < 1000) begin @(negedge clk); c++; end
        dcal = c;
      end
    join
    chk("R12 calib data", data, 8'h42);
    bus_read(1'b0, tmp);
    align();
    fork
      frame_body(8'hE7, 2'b00, 1'b0, 1'b1);
      begin
        repeat (dcal - 1) @(negedge clk);
        addr = 1'b0; wdata = 8'h00; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
      end
    join
    chk("R12 data", data, 8'hE7);
    chk("R12 status", {3'b0, esig, ovr, per, frm, full}, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule